// File: doc/BRIEF.md
# Reset Qualifier and Boot Strap Latch

This block sits between the board-level active-low reset pin and the rest of the chip. It accepts a reset only when the pin has been low for a programmable number of consecutive clock cycles. Shorter dips while the chip is running are filtered out. After a qualified reset, the block keeps the internal core reset asserted until the pin has returned high and the oscillator reports itself stable. Then it runs a short strap hold window.

At the last edge of that window, the block latches two boot straps:
- a code-source pin: high means the core boots from internal code, low means the core boots from external code only;
- a bus-width pin: high means a 16-bit external bus, low means an 8-bit bus.

The latched options are presented at the outputs. The block also sets an initial address size: 20 bits for external-only boot, or a parameterized width for internal boot. Once the core runs, the code-source pin takes on a second role as the external bus wait request. Software may then rewrite the bus width and the address size. An address-size value outside 12..20 is clamped to the nearer limit. A one-cycle notification marks the first cycle of execution, which the core uses to fetch its 16-bit start vector from address 0.

The control is one state machine with five states:
- INIT: the state after power-on. Core reset is held and the block waits for the pin to go low.
- FILTER: counts consecutive low cycles on the pin.
- ASSERTED: reset is qualified. The block waits for the pin to be high and the oscillator to be stable.
- HOLD: counts the strap hold window.
- RUN: the core executes.

The transitions are:
- pin low moves INIT to FILTER and RUN to FILTER;
- a full low count moves FILTER to ASSERTED;
- an early high moves FILTER back to RUN if it came from RUN, otherwise back to INIT;
- pin high together with oscillator stable moves ASSERTED to HOLD;
- pin low or oscillator lost moves HOLD back to ASSERTED;
- the end of the window moves HOLD to RUN.

Top module: `rst_strap_ctrl`

## Requirements
- R1: A reset is qualified on the clock edge at which the pin has been sampled low on MIN_LOW_CYC consecutive edges. Core reset output `core_rst_n` then goes low after that edge. A low pulse of fewer edges while running leaves `core_rst_n` at 1, `rel_pulse` at 0 and all options unchanged.
- R2: After power-on (`por_n` low), `core_rst_n` stays 0 until a qualified reset has been released as in R4.
- R3: While `osc_ok` is 0, `core_rst_n` stays 0 even when the pin is high.
- R4: Let E be the first edge after qualification at which the pin is high and `osc_ok` is 1. `core_rst_n` becomes 1 after edge E+HOLD_CYC-1. If the pin goes low or `osc_ok` drops before that edge, the window restarts from the next such edge without a new low count.
- R5: `rom_less` equals the inverse of `code_pin` sampled at edge E+HOLD_CYC-1 (1 = external-only boot).
- R6: `bus_16` equals `busw_pin` sampled at edge E+HOLD_CYC-1 (1 = 16-bit bus, 0 = 8-bit bus).
- R7: After release, `addr_size` is 20 when `rom_less` is 1 and INT_ASIZE (default 16) when `rom_less` is 0.
- R8: `rel_pulse` is 1 for exactly one cycle: the first cycle in which `core_rst_n` is 1 after a release.
- R9: `bus_wait` equals `code_pin` while `core_rst_n` is 1, and is 0 while `core_rst_n` is 0.
- R10: A write with `sw_busw_we` while running sets `bus_16` to `sw_busw_val` from the next cycle. The same write is ignored while `core_rst_n` is 0.
- R11: A write with `sw_asize_we` while running sets `addr_size` from the next cycle to `sw_asize_val` clamped to 12..20. The same write is ignored while `core_rst_n` is 0.
- R12: After power-on, before any release: `rom_less` = 0, `bus_16` = 1, `addr_size` = 20, `rel_pulse` = 0, `bus_wait` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-good, active low, asynchronous |
| rst_pin_n | input | 1 | External reset pin, active low, synchronous to clk |
| osc_ok | input | 1 | Oscillator stable indication |
| code_pin | input | 1 | Code-source strap during reset; bus wait request afterwards |
| busw_pin | input | 1 | Bus-width strap |
| sw_busw_we | input | 1 | Software bus-width write strobe |
| sw_busw_val | input | 1 | Software bus-width value (1 = 16-bit) |
| sw_asize_we | input | 1 | Software address-size write strobe |
| sw_asize_val | input | ASIZE_W | Requested address size in bits |
| core_rst_n | output | 1 | Internal core reset, active low |
| rom_less | output | 1 | 1 = external-only code boot |
| bus_16 | output | 1 | 1 = 16-bit external bus |
| addr_size | output | ASIZE_W | Current external address size in bits |
| bus_wait | output | 1 | External bus wait request |
| rel_pulse | output | 1 | One-cycle start-of-execution notification |

## Verification
The assertions assume that the reset pin and both straps are already synchronous to `clk`. No synchronizer is in the path, because the strap hold window is counted in edges from the pin's release. The assertions also assume `por_n` is asserted once at power-up. The stimulus meets both assumptions by changing every input just after a falling clock edge and sampling outputs at that point. It then sweeps the strap pairs, every short glitch length, oscillator delays, and every 5-bit address-size value.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_FILTER,
        ST_ASSERTED,
        ST_HOLD,
        ST_RUN
    } rsc_state_e;

    function automatic int unsigned clamp_size(input int unsigned v,
                                               input int unsigned lo,
                                               input int unsigned hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/rsc_fsm.sv
module rsc_fsm
    import rsc_pkg::*;
#(
    parameter int unsigned MIN_LOW_CYC = 2500,
    parameter int unsigned HOLD_CYC    = 3
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_n,
    input  logic osc_ok,
    output logic latch_en,
    output logic core_rst_n,
    output logic rel_pulse
);
    localparam int unsigned CNT_MAX = (MIN_LOW_CYC > HOLD_CYC) ? MIN_LOW_CYC : HOLD_CYC;
    localparam int unsigned CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] LOW_LAST  = CW'(MIN_LOW_CYC - 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] ONE       = CW'(1);

    rsc_state_e    state, nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          from_run, from_run_nxt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state    <= ST_INIT;
            cnt      <= '0;
            from_run <= 1'b0;
        end else begin
            state    <= nxt;
            cnt      <= cnt_nxt;
            from_run <= from_run_nxt;
        end
    end

    always_comb begin
        nxt          = state;
        cnt_nxt      = cnt;
        from_run_nxt = from_run;
        unique case (state)
            ST_INIT: begin
                if (!pin_n) begin
                    nxt          = ST_FILTER;
                    cnt_nxt      = ONE;
                    from_run_nxt = 1'b0;
                end
            end
            ST_RUN: begin
                if (!pin_n) begin
                    nxt          = ST_FILTER;
                    cnt_nxt      = ONE;
                    from_run_nxt = 1'b1;
                end
            end
            ST_FILTER: begin
                if (pin_n) begin
                    nxt     = from_run ? ST_RUN : ST_INIT;
                    cnt_nxt = '0;
                end else if (cnt == LOW_LAST) begin
                    nxt     = ST_ASSERTED;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt + ONE;
                end
            end
            ST_ASSERTED: begin
                if (pin_n && osc_ok) begin
                    nxt     = ST_HOLD;
                    cnt_nxt = ONE;
                end
            end
            ST_HOLD: begin
                if (!pin_n || !osc_ok) begin
                    nxt     = ST_ASSERTED;
                    cnt_nxt = '0;
                end else if (cnt == HOLD_LAST) begin
                    nxt     = ST_RUN;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt + ONE;
                end
            end
            default: begin
                nxt     = ST_INIT;
                cnt_nxt = '0;
            end
        endcase
    end

    // Output process
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) rel_pulse <= 1'b0;
        else        rel_pulse <= latch_en;
    end

    assign latch_en   = (state == ST_HOLD) && (nxt == ST_RUN);
    assign core_rst_n = (state == ST_RUN) || ((state == ST_FILTER) && from_run);

    AST_FALL_NEEDS_LOW: assert property (@(posedge clk) disable iff (!por_n)
        $fell(core_rst_n) |-> $past(!pin_n)); // R1
    AST_RISE_NEEDS_OSC: assert property (@(posedge clk) disable iff (!por_n)
        $rose(core_rst_n) |-> $past(osc_ok) && $past(pin_n)); // R3
    AST_REL_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
        rel_pulse |=> !rel_pulse); // R8
    AST_REL_AT_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
        rel_pulse |-> core_rst_n && !$past(core_rst_n)); // R8

endmodule

// File: rtl/rsc_opt_regs.sv
module rsc_opt_regs
    import rsc_pkg::*;
#(
    parameter int unsigned ASIZE_W   = 5,
    parameter int unsigned ASIZE_MIN = 12,
    parameter int unsigned ASIZE_MAX = 20,
    parameter int unsigned INT_ASIZE = 16
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               latch_en,
    input  logic               running,
    input  logic               code_pin,
    input  logic               busw_pin,
    input  logic               sw_busw_we,
    input  logic               sw_busw_val,
    input  logic               sw_asize_we,
    input  logic [ASIZE_W-1:0] sw_asize_val,
    output logic               rom_less,
    output logic               bus_16,
    output logic [ASIZE_W-1:0] addr_size
);
    localparam logic [ASIZE_W-1:0] SIZE_EXT = ASIZE_W'(ASIZE_MAX);
    localparam logic [ASIZE_W-1:0] SIZE_INT =
        ASIZE_W'(clamp_size(INT_ASIZE, ASIZE_MIN, ASIZE_MAX));

    logic [ASIZE_W-1:0] sw_size_sat;
    assign sw_size_sat = ASIZE_W'(clamp_size(int'(sw_asize_val), ASIZE_MIN, ASIZE_MAX));

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rom_less  <= 1'b0;
            bus_16    <= 1'b1;
            addr_size <= SIZE_EXT;
        end else if (latch_en) begin
            rom_less  <= ~code_pin;
            bus_16    <= busw_pin;
            addr_size <= code_pin ? SIZE_INT : SIZE_EXT;
        end else if (running) begin
            if (sw_busw_we)  bus_16    <= sw_busw_val;
            if (sw_asize_we) addr_size <= sw_size_sat;
        end
    end

    AST_SIZE_IN_RANGE: assert property (@(posedge clk) disable iff (!por_n)
        (addr_size >= ASIZE_W'(ASIZE_MIN)) && (addr_size <= ASIZE_W'(ASIZE_MAX))); // R11
    AST_FROZEN_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
        (!running && !latch_en) |=> $stable({rom_less, bus_16, addr_size})); // R10

endmodule

// File: rtl/rst_strap_ctrl.sv
module rst_strap_ctrl
    import rsc_pkg::*;
#(
    parameter int unsigned MIN_LOW_CYC = 2500,
    parameter int unsigned HOLD_CYC    = 3,
    parameter int unsigned ASIZE_W     = 5,
    parameter int unsigned ASIZE_MIN   = 12,
    parameter int unsigned ASIZE_MAX   = 20,
    parameter int unsigned INT_ASIZE   = 16
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               rst_pin_n,
    input  logic               osc_ok,
    input  logic               code_pin,
    input  logic               busw_pin,
    input  logic               sw_busw_we,
    input  logic               sw_busw_val,
    input  logic               sw_asize_we,
    input  logic [ASIZE_W-1:0] sw_asize_val,
    output logic               core_rst_n,
    output logic               rom_less,
    output logic               bus_16,
    output logic [ASIZE_W-1:0] addr_size,
    output logic               bus_wait,
    output logic               rel_pulse
);
    logic latch_en;

    rsc_fsm #(
        .MIN_LOW_CYC (MIN_LOW_CYC),
        .HOLD_CYC    (HOLD_CYC)
    ) u_fsm (
        .clk        (clk),
        .por_n      (por_n),
        .pin_n      (rst_pin_n),
        .osc_ok     (osc_ok),
        .latch_en   (latch_en),
        .core_rst_n (core_rst_n),
        .rel_pulse  (rel_pulse)
    );

    rsc_opt_regs #(
        .ASIZE_W   (ASIZE_W),
        .ASIZE_MIN (ASIZE_MIN),
        .ASIZE_MAX (ASIZE_MAX),
        .INT_ASIZE (INT_ASIZE)
    ) u_opt (
        .clk          (clk),
        .por_n        (por_n),
        .latch_en     (latch_en),
        .running      (core_rst_n),
        .code_pin     (code_pin),
        .busw_pin     (busw_pin),
        .sw_busw_we   (sw_busw_we),
        .sw_busw_val  (sw_busw_val),
        .sw_asize_we  (sw_asize_we),
        .sw_asize_val (sw_asize_val),
        .rom_less     (rom_less),
        .bus_16       (bus_16),
        .addr_size    (addr_size)
    );

    assign bus_wait = core_rst_n & code_pin;

    AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!por_n)
        $fell(core_rst_n) |-> !bus_wait); // R9

endmodule

// File: tb/tb_rst_strap_ctrl.sv
module tb_rst_strap_ctrl;
    localparam int unsigned MINL = 6;
    localparam int unsigned HOLD = 3;
    localparam int unsigned AW   = 5;

    logic clk = 1'b0;
    logic por_n = 1'b0, rst_pin_n = 1'b1, osc_ok = 1'b1;
    logic code_pin = 1'b1, busw_pin = 1'b1;
    logic sw_busw_we = 1'b0, sw_busw_val = 1'b0, sw_asize_we = 1'b0;
    logic [AW-1:0] sw_asize_val = '0;
    logic core_rst_n, rom_less, bus_16, bus_wait, rel_pulse;
    logic [AW-1:0] addr_size;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rst_strap_ctrl #(.MIN_LOW_CYC(MINL), .HOLD_CYC(HOLD), .ASIZE_W(AW)) dut (
        .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .osc_ok(osc_ok),
        .code_pin(code_pin), .busw_pin(busw_pin),
        .sw_busw_we(sw_busw_we), .sw_busw_val(sw_busw_val),
        .sw_asize_we(sw_asize_we), .sw_asize_val(sw_asize_val),
        .core_rst_n(core_rst_n), .rom_less(rom_less), .bus_16(bus_16),
        .addr_size(addr_size), .bus_wait(bus_wait), .rel_pulse(rel_pulse));

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Qualified low pulse, then release with given straps; checks R4/R5/R6/R7/R8
    task automatic pulse_release(input logic cp, input logic bw);
        rst_pin_n = 1'b0;
        for (int i = 0; i < int'(MINL); i++) tick();
        chk("R1 core reset after full low count", core_rst_n, 0);
        code_pin = cp; busw_pin = bw;
        rst_pin_n = 1'b1;
        for (int i = 0; i < int'(HOLD) - 1; i++) tick();
        chk("R4 still in reset inside hold window", core_rst_n, 0);
        chk("R9 wait quiet in reset", bus_wait, 0);
        tick();
        chk("R4 released at window end", core_rst_n, 1);
        chk("R8 release pulse high", rel_pulse, 1);
        chk("R5 code source latched", rom_less, cp ? 0 : 1);
        chk("R6 bus width latched", bus_16, bw);
        chk("R7 initial address size", addr_size, cp ? 16 : 20);
        tick();
        chk("R8 release pulse one cycle", rel_pulse, 0);
    endtask

    initial begin
        repeat (3) tick();
        chk("R2 reset held during por", core_rst_n, 0);
        por_n = 1'b1;
        repeat (5) tick();
        chk("R2 reset held before first pulse", core_rst_n, 0);
        chk("R12 default rom_less", rom_less, 0);
        chk("R12 default bus_16", bus_16, 1);
        chk("R12 default addr_size", addr_size, 20);
        chk("R12 default rel_pulse", rel_pulse, 0);
        chk("R12 default bus_wait", bus_wait, 0);

        // Strap sweep
        for (int s = 0; s < 4; s++) pulse_release(logic'(s[1]), logic'(s[0]));

        // Straps changed just before the last window edge are the ones taken
        rst_pin_n = 1'b0;
        for (int i = 0; i < int'(MINL); i++) tick();
        code_pin = 1'b1; busw_pin = 1'b1; rst_pin_n = 1'b1;
        for (int i = 0; i < int'(HOLD) - 1; i++) tick();
        code_pin = 1'b0; busw_pin = 1'b0;
        tick();
        chk("R5 strap taken at window end", rom_less, 1);
        chk("R6 strap taken at window end", bus_16, 0);
        code_pin = 1'b1; busw_pin = 1'b1;
        tick();
        chk("R5 strap ignored after latch", rom_less, 1);
        chk("R6 strap ignored after latch", bus_16, 0);

        // Glitch sweep while running
        for (int len = 1; len < int'(MINL); len++) begin
            rst_pin_n = 1'b0;
            for (int i = 0; i < len; i++) begin
                tick();
                chk("R1 short low keeps core running", core_rst_n, 1);
            end
            rst_pin_n = 1'b1;
            tick();
            chk("R1 short low no release pulse", rel_pulse, 0);
            chk("R1 short low options kept", {rom_less, bus_16, addr_size}, {1'b1, 1'b0, 5'd20});
        end

        // Oscillator gating
        osc_ok = 1'b0;
        rst_pin_n = 1'b0;
        for (int i = 0; i < int'(MINL); i++) tick();
        rst_pin_n = 1'b1;
        repeat (10) tick();
        chk("R3 held while oscillator unstable", core_rst_n, 0);
        code_pin = 1'b1; busw_pin = 1'b1;
        osc_ok = 1'b1;
        for (int i = 0; i < int'(HOLD) - 1; i++) tick();
        chk("R3 window starts at oscillator ok", core_rst_n, 0);
        tick();
        chk("R3 released after oscillator ok", core_rst_n, 1);

        // Hold-window restart on pin dip
        rst_pin_n = 1'b0;
        for (int i = 0; i < int'(MINL); i++) tick();
        rst_pin_n = 1'b1;
        tick();
        rst_pin_n = 1'b0;
        tick();
        chk("R4 dip in window keeps reset", core_rst_n, 0);
        rst_pin_n = 1'b1;
        for (int i = 0; i < int'(HOLD) - 1; i++) tick();
        chk("R4 restarted window not yet done", core_rst_n, 0);
        tick();
        chk("R4 restarted window releases", core_rst_n, 1);

        // Wait pin reuse
        code_pin = 1'b0; tick();
        chk("R9 wait follows pin low", bus_wait, 0);
        code_pin = 1'b1; tick();
        chk("R9 wait follows pin high", bus_wait, 1);

        // Software bus width
        for (int v = 0; v < 2; v++) begin
            sw_busw_val = logic'(v); sw_busw_we = 1'b1;
            tick();
            sw_busw_we = 1'b0;
            chk("R10 software bus width", bus_16, v);
        end

        // Software address size sweep
        for (int v = 0; v < 32; v++) begin
            int e;
            e = (v < 12) ? 12 : ((v > 20) ? 20 : v);
            sw_asize_val = AW'(v); sw_asize_we = 1'b1;
            tick();
            sw_asize_we = 1'b0;
            chk("R11 address size clamp", addr_size, e);
        end

        // Writes during reset are ignored
        rst_pin_n = 1'b0;
        for (int i = 0; i < int'(MINL); i++) tick();
        chk("R9 wait quiet in reset", bus_wait, 0);
        sw_busw_val = 1'b0; sw_busw_we = 1'b1;
        sw_asize_val = AW'(13); sw_asize_we = 1'b1;
        tick();
        sw_busw_we = 1'b0; sw_asize_we = 1'b0;
        tick();
        chk("R10 bus width write ignored in reset", bus_16, 1);
        chk("R11 size write ignored in reset", addr_size, 20);
        rst_pin_n = 1'b1;
        repeat (HOLD) tick();
        chk("R4 final release", core_rst_n, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog R2: got 0 expected 1 (run completion)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule